// File: doc/BRIEF.md
# Interleaved Converter Phase Sequencer

This block produces the timing strobes for a bank of time-interleaved successive-approximation converter sections, all driven from a single input clock. One shared phase counter steps through the conversion period. Every section decodes that counter with its own fixed offset, so each section follows the same schedule one clock behind its lower neighbour. At any moment each section is in exactly one slot: reference-zero sampling, auto-zero comparison, auto-calibrate comparison, input sampling, one of the bit trials, or result transfer.

The period is the number of bit trials plus five, and it equals the number of sections. As a result, the input is sampled by exactly one section on every enabled clock. The default of 13 bit trials gives 18 sections and an 18-clock period.

The enable input pauses the whole schedule. While it is low, every strobe is forced low and the phase holds. When it returns high, the schedule resumes from the same point. The analog side, meaning the comparators, the sampling switches and the calibration loops, consumes these strobes and is not part of this block.

Top module: `interleave_sequencer`

## Requirements
- R1: After synchronous reset `rst`, the phase is zero, and section k sits in 0-based slot (−k) mod P, where P = SAR_BITS+5. With the defaults, on the first enabled cycle section 0 asserts `refz_o` and section 15 asserts `samp_o`.
- R2: While `en` is low, all strobe outputs and all bit-index fields are zero. The phase does not advance, so the next enabled cycle shows the same slots as the last enabled cycle would have been followed by.
- R3: Within a section's period, 0-based slot 0 asserts `refz_o[k]`, slot 1 asserts `azero_o[k]`, slot 2 asserts `acal_o[k]` and slot 3 asserts `samp_o[k]`.
- R4: Slots 4 through SAR_BITS+3 assert `sar_o[k]`. The field `bit_idx_o[k*IDX_W +: IDX_W]` then holds the trial bit, counting down from SAR_BITS−1 (MSB) in slot 4 to 0 in the last trial slot, one bit per enabled clock. Outside this window the field is 0.
- R5: The final slot, P−1, asserts `xfer_o[k]` and immediately follows the bit-0 trial.
- R6: Each section's schedule repeats every P enabled clocks.
- R7: Section k's schedule lags section k−1's (mod P) by exactly one enabled clock, so exactly one bit of `samp_o` is high on every enabled cycle.
- R8: A section's transfer strobe comes exactly SAR_BITS+1 enabled clocks after its sample strobe (14 with the defaults).
- R9: On every enabled cycle, each of `refz_o`, `azero_o`, `acal_o` and `xfer_o` has exactly one bit set. Each bit-trial value from 0 to SAR_BITS−1 is held by exactly one section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advances the schedule; low forces all strobes low |
| refz_o | output | P | Reference-zero sample strobe per section |
| azero_o | output | P | Auto-zero comparison strobe per section |
| acal_o | output | P | Auto-calibrate comparison strobe per section |
| samp_o | output | P | Input sample strobe per section |
| sar_o | output | P | Bit-trial window per section |
| xfer_o | output | P | Result transfer strobe per section |
| bit_idx_o | output | P*IDX_W | Per-section current trial bit, field k at k*IDX_W |

## Verification
The bench builds the block with its default parameters: 13 bit trials, 18 sections and a 4-bit index field per section. At this size all 18 phase offsets are exercised, and the counter wraps from slot 17 back to 0 for every section. An enable pattern with isolated low cycles and one long pause shows that the schedule freezes and resumes without a skip. This matters for the sample-to-transfer distance and the per-section repeat interval, which the bench measures in enabled clocks.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    // Slots that come before the bit trials, plus the one transfer slot after them
    localparam int PRE_SLOTS  = 4;
    localparam int POST_SLOTS = 1;

    typedef enum logic [2:0] {
        SLOT_REFZ  = 3'd0,
        SLOT_AZERO = 3'd1,
        SLOT_ACAL  = 3'd2,
        SLOT_SAMP  = 3'd3,
        SLOT_TRIAL = 3'd4,
        SLOT_XFER  = 3'd5
    } slot_kind_e;

    typedef struct packed {
        logic refz;
        logic azero;
        logic acal;
        logic samp;
        logic trial;
        logic xfer;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{default: 1'b0};

    function automatic int period_of(input int sar_bits);
        return PRE_SLOTS + sar_bits + POST_SLOTS;
    endfunction

    // Classify a 0-based slot number
    function automatic slot_kind_e kind_of(input int slot, input int sar_bits);
        slot_kind_e k;
        if (slot == 0)                         k = SLOT_REFZ;
        else if (slot == 1)                    k = SLOT_AZERO;
        else if (slot == 2)                    k = SLOT_ACAL;
        else if (slot == 3)                    k = SLOT_SAMP;
        else if (slot < PRE_SLOTS + sar_bits)  k = SLOT_TRIAL;
        else                                   k = SLOT_XFER;
        return k;
    endfunction

    function automatic strobe_t strobe_of(input slot_kind_e k);
        strobe_t s;
        s = STROBE_IDLE;
        case (k)
            SLOT_REFZ:  s.refz  = 1'b1;
            SLOT_AZERO: s.azero = 1'b1;
            SLOT_ACAL:  s.acal  = 1'b1;
            SLOT_SAMP:  s.samp  = 1'b1;
            SLOT_TRIAL: s.trial = 1'b1;
            default:    s.xfer  = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seq_phase_counter.sv
module seq_phase_counter #(
    parameter  int PERIOD = 18,
    localparam int PH_W   = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output logic [PH_W-1:0] phase_o
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase_q;
    logic [1:0]      hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 2'b00;
        else     hist_q <= {hist_q[0], 1'b1};
    end

    assign phase_o = phase_q;

    // R6: an enabled clock moves the phase one step forward, wrapping after PERIOD steps
    p_advance_r6: assert property (@(posedge clk) disable iff (rst)
        hist_q[1] && $past(adv) |->
            phase_q == (($past(phase_q) == LAST) ? '0 : $past(phase_q) + 1'b1));

    // R2: a disabled clock leaves the phase where it was
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        hist_q[1] && !$past(adv) |-> phase_q == $past(phase_q));

    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        hist_q[0] |-> phase_q <= LAST);

endmodule

// File: rtl/seq_slot_decoder.sv
module seq_slot_decoder
    import phase_seq_pkg::*;
#(
    parameter  int SAR_BITS = 13,
    parameter  int SECT_ID  = 0,
    localparam int PERIOD   = PRE_SLOTS + SAR_BITS + POST_SLOTS,
    localparam int PH_W     = $clog2(PERIOD),
    localparam int IDX_W    = $clog2(SAR_BITS)
) (
    input  logic [PH_W-1:0]  phase_i,
    input  logic             en_i,
    output strobe_t          strobe_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    localparam logic [PH_W-1:0] OFFSET  = PH_W'(SECT_ID);
    localparam logic [PH_W-1:0] WRAP_UP = PH_W'(PERIOD - SECT_ID);
    localparam int              TOP_IDX = SAR_BITS + PRE_SLOTS - 1;

    logic [PH_W-1:0] slot;
    slot_kind_e      kind;
    strobe_t         raw;

    // Subtract this section's offset modulo the period
    always_comb begin
        if (phase_i >= OFFSET) slot = phase_i - OFFSET;
        else                   slot = phase_i + WRAP_UP;
    end

    always_comb begin
        kind = kind_of(int'(slot), SAR_BITS);
        raw  = strobe_of(kind);
    end

    always_comb begin
        strobe_o  = en_i ? raw : STROBE_IDLE;
        bit_idx_o = '0;
        if (en_i && raw.trial) begin
            bit_idx_o = IDX_W'(TOP_IDX - int'(slot));
        end
    end

endmodule

// File: rtl/interleave_sequencer.sv
module interleave_sequencer
    import phase_seq_pkg::*;
#(
    parameter  int SAR_BITS = 13,
    localparam int N_SECT   = PRE_SLOTS + SAR_BITS + POST_SLOTS,
    localparam int PH_W     = $clog2(N_SECT),
    localparam int IDX_W    = $clog2(SAR_BITS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    output logic [N_SECT-1:0]       refz_o,
    output logic [N_SECT-1:0]       azero_o,
    output logic [N_SECT-1:0]       acal_o,
    output logic [N_SECT-1:0]       samp_o,
    output logic [N_SECT-1:0]       sar_o,
    output logic [N_SECT-1:0]       xfer_o,
    output logic [N_SECT*IDX_W-1:0] bit_idx_o
);

    logic [PH_W-1:0] phase;
    strobe_t         strobe [N_SECT];
    logic [1:0]      hist_q;

    seq_phase_counter #(.PERIOD(N_SECT)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .adv     (en),
        .phase_o (phase)
    );

    for (genvar k = 0; k < N_SECT; k++) begin : g_sect
        seq_slot_decoder #(.SAR_BITS(SAR_BITS), .SECT_ID(k)) u_dec (
            .phase_i   (phase),
            .en_i      (en),
            .strobe_o  (strobe[k]),
            .bit_idx_o (bit_idx_o[k*IDX_W +: IDX_W])
        );
        assign refz_o[k]  = strobe[k].refz;
        assign azero_o[k] = strobe[k].azero;
        assign acal_o[k]  = strobe[k].acal;
        assign samp_o[k]  = strobe[k].samp;
        assign sar_o[k]   = strobe[k].trial;
        assign xfer_o[k]  = strobe[k].xfer;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 2'b00;
        else     hist_q <= {hist_q[0], 1'b1};
    end

    // R7: one sampling section per enabled clock
    p_one_sample_r7: assert property (@(posedge clk) disable iff (rst)
        en |-> $countones(samp_o) == 1);

    // R9: the other single-slot strobes are also one-hot across sections
    p_refz_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        en |-> $countones(refz_o) == 1);
    p_xfer_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        en |-> $countones(xfer_o) == 1);

    // R2: nothing fires while disabled
    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !en |-> (samp_o | refz_o | sar_o | xfer_o | azero_o | acal_o) == '0);

    for (genvar k = 0; k < N_SECT; k++) begin : g_chk
        localparam int NXT = (k + 1) % N_SECT;
        // R7: the neighbour samples one enabled clock later
        p_stagger_r7: assert property (@(posedge clk) disable iff (rst)
            hist_q[1] && en && $past(en) && $past(samp_o[k]) |-> samp_o[NXT]);
        // R4: the first trial after the sample slot is the MSB
        p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
            hist_q[1] && en && $past(en) && $past(samp_o[k]) |->
                sar_o[k] && bit_idx_o[k*IDX_W +: IDX_W] == IDX_W'(SAR_BITS - 1));
        // R5: transfer follows the bit-0 trial
        p_xfer_after_lsb_r5: assert property (@(posedge clk) disable iff (rst)
            hist_q[1] && en && $past(en) && xfer_o[k] |->
                $past(sar_o[k]) && $past(bit_idx_o[k*IDX_W +: IDX_W]) == '0);
    end

endmodule

// File: tb/tb_interleave_sequencer.sv
`timescale 1ns/1ps
module tb_interleave_sequencer;

    localparam int SAR_BITS = 13;
    localparam int NS       = SAR_BITS + 5;
    localparam int IW       = $clog2(SAR_BITS);
    localparam int NCYC     = 420;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [NS-1:0]    refz_o, azero_o, acal_o, samp_o, sar_o, xfer_o;
    logic [NS*IW-1:0] bit_idx_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    interleave_sequencer #(.SAR_BITS(SAR_BITS)) dut (
        .clk(clk), .rst(rst), .en(en),
        .refz_o(refz_o), .azero_o(azero_o), .acal_o(acal_o),
        .samp_o(samp_o), .sar_o(sar_o), .xfer_o(xfer_o),
        .bit_idx_o(bit_idx_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int field(input int k);
        return int'(bit_idx_o[k*IW +: IW]);
    endfunction

    function automatic bit pattern_en(input int i);
        if (i < 40) return 1'b1;
        if (i >= 200 && i < 215) return 1'b0;
        return (i % 7) != 3;
    endfunction

    // Reference model: phase integer, section slots derived arithmetically
    int ph = 0;
    int ec = 0;
    int last_samp [NS];
    int last_seen [NS];

    initial begin
        for (int k = 0; k < NS; k++) begin
            last_samp[k] = -1;
            last_seen[k] = -1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        // R1: first enabled cycle after reset
        #0.5;
        check("R1", "refz section0", int'(refz_o[0]), 1);
        check("R1", "samp section15", int'(samp_o[15]), 1);
        check("R1", "xfer section1", int'(xfer_o[1]), 1);
        for (int i = 0; i < NCYC; i++) begin
            int bad3, bad4, bad5, bad7, bad2, nsamp, nrefz, nxfer;
            int idxcnt [SAR_BITS];
            if (i > 0) @(negedge clk);
            bad3 = 0; bad4 = 0; bad5 = 0; bad7 = 0; bad2 = 0;
            nsamp = 0; nrefz = 0; nxfer = 0;
            for (int b = 0; b < SAR_BITS; b++) idxcnt[b] = 0;
            for (int k = 0; k < NS; k++) begin
                int s, e_idx;
                bit e_trial;
                s = (ph - k + NS) % NS;
                e_trial = en && s >= 4 && s <= SAR_BITS + 3;
                e_idx = e_trial ? SAR_BITS + 3 - s : 0;
                if (refz_o[k]  != (en && s == 0)) bad3++;
                if (azero_o[k] != (en && s == 1)) bad3++;
                if (acal_o[k]  != (en && s == 2)) bad3++;
                if (samp_o[k]  != (en && s == 3)) bad7++;
                if (sar_o[k] != e_trial || field(k) != e_idx) bad4++;
                if (xfer_o[k]  != (en && s == NS - 1)) bad5++;
                if (!en && (sar_o[k] || field(k) != 0 || samp_o[k] || refz_o[k] || xfer_o[k])) bad2++;
                if (samp_o[k]) nsamp++;
                if (refz_o[k]) nrefz++;
                if (xfer_o[k]) nxfer++;
                if (sar_o[k] && field(k) < SAR_BITS) idxcnt[field(k)]++;
                if (en && samp_o[k]) begin
                    if (last_samp[k] >= 0) check("R6", "sample repeat interval", ec - last_samp[k], NS);
                    last_samp[k] = ec;
                end
                if (en && xfer_o[k] && last_samp[k] >= 0)
                    check("R8", "sample to transfer distance", ec - last_samp[k], SAR_BITS + 1);
            end
            check("R3", "calibration slot mismatches", bad3, 0);
            check("R4", "trial window or bit index mismatches", bad4, 0);
            check("R5", "transfer slot mismatches", bad5, 0);
            check("R7", "sample strobe mismatches", bad7, 0);
            if (en) begin
                check("R7", "sampling sections", nsamp, 1);
                check("R9", "refz sections", nrefz, 1);
                check("R9", "xfer sections", nxfer, 1);
                for (int b = 0; b < SAR_BITS; b++)
                    check("R9", $sformatf("holders of bit %0d", b), idxcnt[b], 1);
            end else begin
                check("R2", "activity while disabled", bad2, 0);
            end
            // model advance at the coming edge
            if (en) begin
                ph = (ph + 1) % NS;
                ec++;
            end
            en = pattern_en(i + 1);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule